// File: doc/BRIEF.md
# Fast Single-Word Mailbox Channels

This block gives a sending agent eight independent one-word message slots toward a receiving agent. Writing a word into a slot keeps the word and marks a pending event for that slot. The receiver finds the event in a status word that the rest of the mailbox also uses, acknowledges it by writing a one to the matching bit of a clear register, and then reads the word back from the slot. The sender gets no completion indication. It is the lowest-latency path in the mailbox: one bus write for each message.

The event bits sit at positions 9 to 16 of the shared status, clear and receiver-mask words, above the bits owned by the mailbox's other channels. The receiver interrupt line is a registered OR of the pending events that are enabled by the receiver mask. Channels do not interact. A slot that is written again before it is cleared takes the newer word and stays pending.

Top module: `fast_word_chan`

## Requirements
- R1: A write to byte address 0x8C + 4*n (n = 0..7) stores the 32-bit word in slot n. A read of that address returns the word. The other slots keep their contents.
- R2: A write to slot n sets status bit 9+n, which is read at address 0xC8. All other status bits read 0.
- R3: A write to the clear register at 0xC4 with bit 9+n set clears event n. The word in slot n is kept.
- R4: Zero bits of a clear write, and bits outside 9..16, have no effect on any event.
- R5: A second write to a pending slot replaces the word and leaves the event set. No other status bit changes.
- R6: The receiver mask at 0xC0 keeps bits 9..16 of the written word. A read returns them in place, with every other bit 0.
- R7: irq_rx is high in the cycle after a cycle in which some event n is pending and mask bit 9+n is set, and low otherwise. A masked event still shows in the status.
- R8: A read returns its data on rdata in the cycle after rd_en. Unmapped, misaligned and clear-register addresses read 0. rdata holds its value between reads.
- R9: Reset clears all slot words, events, the mask, irq_rx and rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_rx | output | 1 | Receiver interrupt, registered |

## Verification
A wrong event bit shows up in two places. The status word shows it on the next read, and irq_rx shows it one cycle after the mask enables the bit. A corrupted slot word stays hidden until that slot is read. For this reason the bench compares irq_rx and rdata against a behavioural model on every clock, and it reads every slot back after each pattern. A clear that reaches the wrong channel shows as a stuck or missing status bit on the very next status read.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int SLOT_BASE = 'h8C;
  localparam int MASK_OFF  = 'hC0;
  localparam int CLR_OFF   = 'hC4;
  localparam int STAT_OFF  = 'hC8;
  localparam int EVT_BASE  = 9;

  typedef enum logic [2:0] {
    RG_NONE, RG_SLOT, RG_MASK, RG_CLR, RG_STAT
  } fwc_region_e;
endpackage

// File: rtl/fwc_decode.sv
module fwc_decode
  import fwc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output fwc_region_e       region_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int SPAN = 4 * NUM_CH;

  logic [ADDR_W-1:0] rel;
  logic              aligned;

  always_comb begin
    rel      = addr_i - ADDR_W'(SLOT_BASE);
    aligned  = (addr_i[1:0] == 2'b00);
    idx_o    = rel[IDX_W+1:2];
    region_o = RG_NONE;
    if (aligned) begin
      if (addr_i >= ADDR_W'(SLOT_BASE) && rel < ADDR_W'(SPAN)) region_o = RG_SLOT;
      else if (addr_i == ADDR_W'(MASK_OFF))                    region_o = RG_MASK;
      else if (addr_i == ADDR_W'(CLR_OFF))                     region_o = RG_CLR;
      else if (addr_i == ADDR_W'(STAT_OFF))                    region_o = RG_STAT;
    end
  end
endmodule

// File: rtl/fwc_slot.sv
module fwc_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o,
  output logic              evt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      evt_o  <= 1'b0;
    end else begin
      if (wr_i) data_o <= wdata_i;
      if (wr_i)       evt_o <= 1'b1;
      else if (clr_i) evt_o <= 1'b0;
    end
  end

  p_set_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> evt_o);
  p_capture_r1: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> data_o == $past(wdata_i));
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !wr_i) |=> !evt_o);
  p_keep_word_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(data_o));
endmodule

// File: rtl/fwc_irq.sv
module fwc_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr_i,
  input  logic [NUM_CH-1:0] mask_d_i,
  input  logic [NUM_CH-1:0] evt_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic              irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_o <= mask_d_i;
      irq_o <= |(evt_i & mask_o);
    end
  end

  p_irq_needs_event_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|evt_i));
  p_no_mask_no_irq_r7: assert property (@(posedge clk) disable iff (rst)
    (mask_o == '0 && !$past(mask_wr_i)) |=> !irq_o);
endmodule

// File: rtl/fast_word_chan.sv
module fast_word_chan
  import fwc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_rx
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int EVT_HI = EVT_BASE + NUM_CH - 1;

  fwc_region_e              region;
  logic [IDX_W-1:0]         idx;
  logic [NUM_CH-1:0]        evt;
  logic [NUM_CH-1:0]        mask;
  logic [DATA_W-1:0]        slot_data [NUM_CH];
  logic [DATA_W-1:0]        rd_mux;

  fwc_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i(addr), .region_o(region), .idx_o(idx)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic wr_g, clr_g;
    assign wr_g  = wr_en && (region == RG_SLOT) && (idx == IDX_W'(g));
    assign clr_g = wr_en && (region == RG_CLR) && wdata[EVT_BASE+g];
    fwc_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst), .wr_i(wr_g), .clr_i(clr_g),
      .wdata_i(wdata), .data_o(slot_data[g]), .evt_o(evt[g])
    );
  end

  fwc_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst),
    .mask_wr_i(wr_en && region == RG_MASK),
    .mask_d_i(wdata[EVT_HI:EVT_BASE]),
    .evt_i(evt), .mask_o(mask), .irq_o(irq_rx)
  );

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_SLOT: rd_mux = slot_data[idx];
      RG_STAT: rd_mux[EVT_HI:EVT_BASE] = evt;
      RG_MASK: rd_mux[EVT_HI:EVT_BASE] = mask;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && region == RG_NONE) |=> rdata == '0);
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  p_status_confined_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && region == RG_STAT) |=> $countones(rdata) <= NUM_CH);
endmodule

// File: tb/tb_fast_word_chan.sv
`timescale 1ns/1ps
module tb_fast_word_chan;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_rx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fast_word_chan dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_rx(irq_rx)
  );

  // behavioural reference model
  int unsigned m_data [8];
  int unsigned m_evt, m_mask, m_rdata;
  bit          m_irq;

  always @(posedge clk) begin
    int unsigned rv;
    if (rst) begin
      foreach (m_data[i]) m_data[i] = 0;
      m_evt = 0; m_mask = 0; m_rdata = 0; m_irq = 0;
    end else begin
      rv = 0;
      if (addr >= 8'h8C && addr <= 8'hA8 && addr[1:0] == 0) rv = m_data[(addr - 8'h8C) / 4];
      else if (addr == 8'hC8) rv = m_evt;
      else if (addr == 8'hC0) rv = m_mask;
      if (rd_en) m_rdata = rv;
      m_irq = ((m_evt & m_mask) != 0);
      if (wr_en) begin
        if (addr >= 8'h8C && addr <= 8'hA8 && addr[1:0] == 0) begin
          m_data[(addr - 8'h8C) / 4] = wdata;
          m_evt |= (32'h1 << (9 + (addr - 8'h8C) / 4));
        end else if (addr == 8'hC0) m_mask = wdata & 32'h0001FE00;
        else if (addr == 8'hC4)     m_evt &= ~(wdata & 32'h0001FE00);
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R8 rdata vs model", rdata, m_rdata);
    chk("R7 irq vs model", {31'b0, irq_rx}, {31'b0, m_irq});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = 8'h00; wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0; addr = 8'h00;
    v = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    idle(3);
    rst = 0;
    // R9 reset state
    chk("R9 irq after reset", {31'b0, irq_rx}, 0);
    chk("R9 rdata after reset", rdata, 0);
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h8C + 4*n), v); chk("R9 slot cleared", v, 0);
    end
    rd(8'hC8, v); chk("R9 status cleared", v, 0);
    rd(8'hC0, v); chk("R9 mask cleared", v, 0);

    // R1/R2 single write, masked
    wr(8'h98, 32'hA5A5_5A5A);
    rd(8'h98, v); chk("R1 slot3 word", v, 32'hA5A5_5A5A);
    rd(8'hC8, v); chk("R2 status bit 12", v, 32'h0000_1000);
    chk("R7 masked no irq", {31'b0, irq_rx}, 0);

    // R6 mask storage, R7 irq rises
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, v); chk("R6 mask bits 9..16", v, 32'h0001_FE00);
    chk("R7 irq enabled", {31'b0, irq_rx}, 1);

    // R5 overwrite while pending
    wr(8'h98, 32'h0000_1234);
    rd(8'h98, v); chk("R5 overwrite word", v, 32'h0000_1234);
    rd(8'hC8, v); chk("R5 status unchanged", v, 32'h0000_1000);

    // R4 clear with other bits only
    wr(8'hC4, ~32'h0000_1000);
    rd(8'hC8, v); chk("R4 stray clear ignored", v, 32'h0000_1000);
    // R3 clear keeps word
    wr(8'hC4, 32'h0000_1000);
    rd(8'hC8, v); chk("R3 event cleared", v, 0);
    rd(8'h98, v); chk("R3 word kept", v, 32'h0000_1234);
    chk("R7 irq drops", {31'b0, irq_rx}, 0);

    // R1/R2 all channels
    for (int n = 0; n < 8; n++) wr(8'(8'h8C + 4*n), 32'hC0DE_0000 + 32'(n * 17));
    for (int n = 0; n < 8; n++) begin
      rd(8'(8'h8C + 4*n), v); chk("R1 slot readback", v, 32'hC0DE_0000 + 32'(n * 17));
    end
    rd(8'hC8, v); chk("R2 all pending", v, 32'h0001_FE00);

    // R7 mask only channel 0, then clear channel 0
    wr(8'hC0, 32'h0000_0200);
    wr(8'hC4, 32'h0000_0200);
    idle(2);
    chk("R7 masked pending no irq", {31'b0, irq_rx}, 0);
    rd(8'hC8, v); chk("R7 masked still in status", v, 32'h0001_FC00);

    // R8 unmapped / misaligned / clear reg read zero, hold
    rd(8'h00, v); chk("R8 unmapped zero", v, 0);
    rd(8'h90, v); chk("R8 slot1 read", v, 32'hC0DE_0011);
    idle(3);
    chk("R8 rdata holds", rdata, 32'hC0DE_0011);
    rd(8'h8D, v); chk("R8 misaligned zero", v, 0);
    rd(8'hC4, v); chk("R8 clear reg zero", v, 0);

    // R9 reset in mid-run
    wr(8'hC0, 32'h0001_FE00);
    idle(2);
    rst = 1; idle(2); rst = 0;
    chk("R9 irq low", {31'b0, irq_rx}, 0);
    rd(8'hC8, v); chk("R9 events cleared", v, 0);
    rd(8'hAC - 4, v); chk("R9 slot7 cleared", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule